// File: doc/BRIEF.md
# Multi-Level FSK Deviation Mapper

This block turns transmit symbols into a signed frequency offset. A synthesizer adds that offset to its fractional-N word. It serves three symbol sources: binary FSK, four-level FSK with Gray-coded dibits, and three-level FSK taken from a duobinary encoder (levels 0, +1, −1). A 9-bit deviation code sets the size of one deviation step. An RF divide-by-2 flag halves that step, because the divided output would otherwise show twice the intended deviation.

The block keeps exact half-steps by giving the output one fractional bit. One output LSB is therefore PFD/2^17, which is half of the synthesizer's PFD/2^16 fractional unit. The block latches a new offset each time the source marks a symbol valid. It holds that offset between symbols.

Top module: `fsk_dev_mapper`

## Requirements
- R1: While rst_ni is low, offset_o is 0 and offset_valid_o is 0. Both take those values as soon as rst_ni falls, without waiting for a clock edge.
- R2: A symbol presented with sym_valid_i high at a rising edge appears on offset_o after that edge. offset_valid_o is high for exactly the cycle after each valid edge.
- R3: At an edge where sym_valid_i is low, offset_o keeps its value whatever scheme_i, dev_code_i, rf_div2_i and sym_i do, and offset_valid_o goes low.
- R4: When scheme_i = 3'b000 (binary FSK), sym_i[0] = 1 gives +1 step and sym_i[0] = 0 gives −1 step. sym_i[1] is ignored.
- R5: When scheme_i = 3'b010 (four-level FSK), the sym_i dibits map onto step multiples as follows: 2'b00 → −3, 2'b01 → −1, 2'b11 → +1, 2'b10 → +3.
- R6: When scheme_i = 3'b001 (three-level FSK), sym_i is a 2-bit two's-complement level: 2'b00 → 0, 2'b01 → +1, 2'b11 → −1. The unused code 2'b10 gives 0.
- R7: Any scheme_i code other than 3'b000, 3'b001 or 3'b010 gives offset 0.
- R8: With rf_div2_i low, one step equals 2 × dev_code_i output LSBs (LSB = PFD/2^17). At dev_code_i = 511, the four-level extremes are ±3066.
- R9: With rf_div2_i high, one step equals dev_code_i output LSBs, which is half the direct-output step.
- R10: A dev_code_i of 0 is treated as 1. The step is then 2 LSBs with rf_div2_i low and 1 LSB with rf_div2_i high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scheme_i | input | 3 | Modulation scheme code |
| dev_code_i | input | 9 | Deviation code, unit PFD/2^16 |
| rf_div2_i | input | 1 | RF divide-by-2 on; halves the step |
| sym_valid_i | input | 1 | Symbol on sym_i is valid this cycle |
| sym_i | input | 2 | Symbol bit, dibit or three-level code |
| offset_o | output | 13 | Signed offset, LSB = PFD/2^17 |
| offset_valid_o | output | 1 | Offset updated at the last edge |

## Verification
Two cases are hard to reach from the ports. The first is the half-LSB step, the only place where the divide-by-2 flag shows up as an odd output value. The bench reaches it by pairing rf_div2_i high with odd codes, including the clamped zero code, which must give exactly −1. The second is that held values ignore their inputs. For this the bench drops sym_valid_i and then changes every other input together, including switching to an unused scheme that would give zero. An unchanged nonzero output then shows that nothing leaked through.

// File: rtl/fsk_dev_pkg.sv
package fsk_dev_pkg;

  typedef enum logic [2:0] {
    SCH_2FSK = 3'b000,
    SCH_3FSK = 3'b001,
    SCH_4FSK = 3'b010
  } scheme_e;

  // signed step multiple: magnitude 0, 1 or 3
  typedef struct packed {
    logic       neg;
    logic [1:0] mag;
  } level_t;

endpackage

// File: rtl/fsk_dev_step.sv
module fsk_dev_step #(
  parameter int DEV_W = 9
) (
  input  logic [DEV_W-1:0] dev_code_i,
  input  logic             rf_div2_i,
  output logic [DEV_W:0]   step_o
);
  logic [DEV_W-1:0] code_clamped;

  always_comb begin
    code_clamped = (dev_code_i == '0) ? DEV_W'(1) : dev_code_i;
    // output has one fractional bit: direct = 2*code, divided = code
    step_o = rf_div2_i ? {1'b0, code_clamped} : {code_clamped, 1'b0};
  end
endmodule

// File: rtl/fsk_level_map.sv
module fsk_level_map
  import fsk_dev_pkg::*;
(
  input  logic [2:0] scheme_i,
  input  logic [1:0] sym_i,
  output level_t     level_o
);
  always_comb begin
    level_o = '0;
    case (scheme_i)
      SCH_2FSK: begin
        level_o.neg = ~sym_i[0];
        level_o.mag = 2'd1;
      end
      SCH_4FSK: begin
        // Gray order from the lowest level up
        case (sym_i)
          2'b00:   level_o = '{neg: 1'b1, mag: 2'd3};
          2'b01:   level_o = '{neg: 1'b1, mag: 2'd1};
          2'b11:   level_o = '{neg: 1'b0, mag: 2'd1};
          default: level_o = '{neg: 1'b0, mag: 2'd3};
        endcase
      end
      SCH_3FSK: begin
        case (sym_i)
          2'b01:   level_o = '{neg: 1'b0, mag: 2'd1};
          2'b11:   level_o = '{neg: 1'b1, mag: 2'd1};
          default: level_o = '0;
        endcase
      end
      default: level_o = '0;
    endcase
  end
endmodule

// File: rtl/fsk_level_scale.sv
module fsk_level_scale
  import fsk_dev_pkg::*;
#(
  parameter int STEP_W = 10,
  localparam int MAG_W = STEP_W + 2,
  localparam int OUT_W = MAG_W + 1
) (
  input  level_t                   level_i,
  input  logic [STEP_W-1:0]        step_i,
  output logic signed [OUT_W-1:0]  offset_o
);
  logic [MAG_W-1:0] mag_sum;

  // shift-add in place of a multiplier: mag is 0, 1 or 3
  always_comb begin
    mag_sum = '0;
    if (level_i.mag[0]) mag_sum = mag_sum + MAG_W'(step_i);
    if (level_i.mag[1]) mag_sum = mag_sum + (MAG_W'(step_i) << 1);
    offset_o = level_i.neg ? -$signed({1'b0, mag_sum}) : $signed({1'b0, mag_sum});
  end
endmodule

// File: rtl/fsk_dev_mapper.sv
module fsk_dev_mapper
  import fsk_dev_pkg::*;
#(
  parameter int DEV_W = 9,
  localparam int STEP_W = DEV_W + 1,
  localparam int OUT_W = DEV_W + 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [2:0]              scheme_i,
  input  logic [DEV_W-1:0]        dev_code_i,
  input  logic                    rf_div2_i,
  input  logic                    sym_valid_i,
  input  logic [1:0]              sym_i,
  output logic signed [OUT_W-1:0] offset_o,
  output logic                    offset_valid_o
);
  logic [STEP_W-1:0]        step_w;
  level_t                   level_w;
  logic signed [OUT_W-1:0]  offset_d;

  fsk_dev_step #(.DEV_W(DEV_W)) u_step (
    .dev_code_i (dev_code_i),
    .rf_div2_i  (rf_div2_i),
    .step_o     (step_w)
  );

  fsk_level_map u_map (
    .scheme_i (scheme_i),
    .sym_i    (sym_i),
    .level_o  (level_w)
  );

  fsk_level_scale #(.STEP_W(STEP_W)) u_scale (
    .level_i  (level_w),
    .step_i   (step_w),
    .offset_o (offset_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      offset_o       <= '0;
      offset_valid_o <= 1'b0;
    end else begin
      offset_valid_o <= sym_valid_i;
      if (sym_valid_i) offset_o <= offset_d;
    end
  end

  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_valid_i |=> offset_valid_o) else $error("valid latency"); // R2

  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sym_valid_i |=> ($stable(offset_o) && !offset_valid_o)) else $error("hold"); // R3

  AST_UNUSED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_i && scheme_i > 3'b010) |=> (offset_o == '0)) else $error("unused scheme"); // R7

  AST_2FSK_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_i && scheme_i == SCH_2FSK) |=> ((offset_o > 0) == $past(sym_i[0])))
    else $error("2fsk sign"); // R4

  AST_STEP_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_i && scheme_i == SCH_2FSK) |=> (offset_o != '0)) else $error("zero step"); // R10
endmodule

// File: tb/fsk_dev_mapper_test.sv
module fsk_dev_mapper_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 20;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [2:0]        scheme = '0;
  logic [8:0]        dev_code = '0;
  logic              div2 = 1'b0;
  logic              sym_valid = 1'b0;
  logic [1:0]        sym = '0;
  logic signed [12:0] offset;
  logic              offset_valid;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fsk_dev_mapper uut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .scheme_i       (scheme),
    .dev_code_i     (dev_code),
    .rf_div2_i      (div2),
    .sym_valid_i    (sym_valid),
    .sym_i          (sym),
    .offset_o       (offset),
    .offset_valid_o (offset_valid)
  );

  // {scheme, dev_code, div2, sym, expected offset}
  localparam logic [27:0] VEC [NVEC] = '{
    {3'd0, 9'd100, 1'b0, 2'b01,  13'sd200},   // R4 R8
    {3'd0, 9'd100, 1'b0, 2'b00, -13'sd200},   // R4
    {3'd0, 9'd100, 1'b0, 2'b10, -13'sd200},   // R4 sym[1] ignored
    {3'd2, 9'd5,   1'b0, 2'b00, -13'sd30},    // R5
    {3'd2, 9'd5,   1'b0, 2'b01, -13'sd10},    // R5
    {3'd2, 9'd5,   1'b0, 2'b11,  13'sd10},    // R5
    {3'd2, 9'd5,   1'b0, 2'b10,  13'sd30},    // R5
    {3'd1, 9'd7,   1'b0, 2'b00,  13'sd0},     // R6
    {3'd1, 9'd7,   1'b0, 2'b01,  13'sd14},    // R6
    {3'd1, 9'd7,   1'b0, 2'b11, -13'sd14},    // R6
    {3'd1, 9'd7,   1'b0, 2'b10,  13'sd0},     // R6
    {3'd0, 9'd33,  1'b1, 2'b01,  13'sd33},    // R9
    {3'd2, 9'd511, 1'b0, 2'b10,  13'sd3066},  // R8
    {3'd2, 9'd511, 1'b0, 2'b00, -13'sd3066},  // R8
    {3'd2, 9'd511, 1'b1, 2'b00, -13'sd1533},  // R9
    {3'd0, 9'd0,   1'b0, 2'b01,  13'sd2},     // R10
    {3'd0, 9'd0,   1'b1, 2'b00, -13'sd1},     // R10
    {3'd3, 9'd100, 1'b0, 2'b01,  13'sd0},     // R7
    {3'd7, 9'd100, 1'b0, 2'b10,  13'sd0},     // R7
    {3'd1, 9'd3,   1'b1, 2'b11, -13'sd3}      // R9 R6
  };

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    chk("R1 offset in reset", int'(offset), 0);
    chk("R1 valid in reset", int'(offset_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3 idle valid low", int'(offset_valid), 0);

    for (int i = 0; i < NVEC; i++) begin
      scheme    = VEC[i][27:25];
      dev_code  = VEC[i][24:16];
      div2      = VEC[i][15];
      sym       = VEC[i][14:13];
      sym_valid = 1'b1;
      @(negedge clk);
      chk($sformatf("R%0d vector %0d offset", i < 3 ? 4 : 8, i), int'(offset),
          int'($signed(VEC[i][12:0])));
      chk("R2 valid after symbol", int'(offset_valid), 1);
    end

    // R3: hold with all other inputs moving
    scheme = 3'd2; dev_code = 9'd50; div2 = 1'b0; sym = 2'b10; sym_valid = 1'b1;
    @(negedge clk);
    chk("R5 setup +3", int'(offset), 300);
    sym_valid = 1'b0;
    scheme = 3'd5; dev_code = 9'd1; div2 = 1'b1; sym = 2'b00;
    @(negedge clk);
    chk("R3 hold offset", int'(offset), 300);
    chk("R2 valid one cycle only", int'(offset_valid), 0);
    scheme = 3'd0; sym = 2'b01;
    @(negedge clk);
    chk("R3 hold second cycle", int'(offset), 300);

    // R2: single-cycle valid pulse
    scheme = 3'd0; dev_code = 9'd9; div2 = 1'b0; sym = 2'b00; sym_valid = 1'b1;
    @(negedge clk);
    sym_valid = 1'b0;
    chk("R2 offset updated", int'(offset), -18);
    chk("R2 valid high", int'(offset_valid), 1);
    @(negedge clk);
    chk("R2 valid drops", int'(offset_valid), 0);

    // R1: asynchronous reset mid-run
    #(CLK_PERIOD/4);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset offset", int'(offset), 0);
    @(negedge clk);
    chk("R1 reset valid", int'(offset_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule